// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block keeps the pending, in-service and trigger-type state of a bank of interrupt vectors. It is meant to sit beside a processor core. It raises a request line when a pending vector outranks the current processor priority. It hands over a vector when the core acknowledges, and it retires the most important in-service vector when the core signals end of interrupt. Level-triggered vectors get a one-cycle broadcast strobe on retirement, so that upstream sources can re-sample their lines. A strap bit in the stored spurious-vector value can suppress this strobe.

Each vector is its own bit, and the vector number is its priority: a larger number is more urgent. The upper nibble of a vector is its priority class. The processor priority combines the task priority input with the class of the most urgent in-service vector. Only a pending vector whose class is strictly above that priority is presented to the core. Vectors are stored in words of a parameterized width, and the search scans the highest word first.

Top module: `vpa_arbiter`

## Requirements
- R1: When several vectors are pending, an acknowledge grants the highest-numbered one. The search runs from the top word downwards, and within a word from the top bit.
- R2: A set request raises the vector's pending bit. The trigger bit of that vector becomes 1 when set_level is high and 0 when it is low. The trigger bit is seen through the broadcast that occurs when the vector is later retired.
- R3: irq is low whenever bit 8 (enable) of the stored spurious-vector value is 0, or no vector is pending.
- R4: When the processor priority is nonzero, the highest pending vector raises irq only if its class (bits 7:4) is strictly greater than the priority's bits 7:4. A zero priority lets any pending vector through.
- R5: The processor priority is tpr when tpr[7:4] is at least the class of the highest in-service vector, or when nothing is in service. Otherwise it is that vector with its low nibble cleared.
- R6: An acknowledge while irq is high clears the granted vector's pending bit and sets its in-service bit. One cycle later it pulses ack_valid with ack_vector equal to the vector and ack_spurious low.
- R7: An acknowledge while irq is low changes no state. One cycle later it pulses ack_valid with ack_spurious high and ack_vector equal to bits 7:0 of the stored spurious-vector value.
- R8: An end of interrupt clears the highest in-service bit. If that vector's trigger bit is 1 and bit 12 (directed) of the stored spurious-vector value is 0, eoi_bcast pulses for one cycle on the next cycle, with eoi_vector equal to that vector.
- R9: An end of interrupt with nothing in service changes no state and produces no broadcast.
- R10: A write to the spurious-vector value stores bits 8:0, and also bit 12 when DIRECTED_EOI_EN is 1. All other bits are stored as 0.
- R11: After reset nothing is pending, in service or level-triggered. The stored spurious-vector value is 0x0FF, so the block is disabled and spurious acknowledges return 0xFF. All outputs are low.
- R12: All inputs in one cycle act on the state from before the edge. A vector set in the same cycle that the same vector is granted stays pending and also enters service. A vector cleared by end of interrupt in the same cycle that it is granted ends up in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Raise a vector's pending bit |
| set_vector | input | VEC_W | Vector to raise |
| set_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack | input | 1 | Core acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr | input | 8 | Task priority |
| svr_wr | input | 1 | Write strobe for the spurious-vector value |
| svr_wdata | input | SVR_W | Spurious-vector write data |
| irq | output | 1 | Request line to the core (combinational) |
| ack_valid | output | 1 | Acknowledge result strobe |
| ack_vector | output | 8 | Granted or spurious vector |
| ack_spurious | output | 1 | Acknowledge returned the spurious vector |
| eoi_bcast | output | 1 | Level-triggered retirement strobe |
| eoi_vector | output | VEC_W | Vector carried by eoi_bcast |

## Verification
Set, acknowledge and end of interrupt can all fall in the same cycle. The critical case is a set that targets the very vector the acknowledge grants, and a retirement racing a grant. The bench provokes this with a directed case that sets the pending winner while acknowledging it. It also uses random traffic where all three strobes are frequent together. A bench model that applies every input to the pre-edge state judges the pending, in-service and broadcast results, as well as the combinational request line.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
   localparam int PRIO_W = 8;
   typedef logic [PRIO_W-1:0] prio_t;

   function automatic logic [3:0] prio_class(input prio_t p);
      return p[7:4];
   endfunction
endpackage

// File: rtl/vpa_hi_find.sv
module vpa_hi_find #(
   parameter int NUM_BITS = 256,
   parameter int WORD_W   = 32,
   localparam int IDX_W   = $clog2(NUM_BITS),
   localparam int NWORDS  = NUM_BITS / WORD_W,
   localparam int BIT_W   = $clog2(WORD_W)
) (
   input  logic [NUM_BITS-1:0] bits,
   output logic                found,
   output logic [IDX_W-1:0]    idx
);
   if (NUM_BITS % WORD_W != 0) begin : g_bad_split
      $error("NUM_BITS must be a multiple of WORD_W");
   end
   if ((1 << BIT_W) != WORD_W) begin : g_bad_word
      $error("WORD_W must be a power of two");
   end

   logic [NWORDS-1:0] word_hit;
   logic [BIT_W-1:0]  word_pos [NWORDS];

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      always_comb begin
         word_hit[w] = 1'b0;
         word_pos[w] = '0;
         for (int b = 0; b < WORD_W; b++) begin
            if (bits[w*WORD_W + b]) begin
               word_hit[w] = 1'b1;
               word_pos[w] = BIT_W'(b);
            end
         end
      end
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int w = 0; w < NWORDS; w++) begin
         if (word_hit[w]) begin
            found = 1'b1;
            idx   = IDX_W'(w * WORD_W) | IDX_W'(word_pos[w]);
         end
      end
   end

   // R1
   always_comb begin
      if (found) begin
         hit_is_set_chk: assert (bits[idx]);
      end
   end
   // R1
   always_comb begin
      if (!found) begin
         miss_is_empty_chk: assert (bits == '0);
      end
   end
endmodule

// File: rtl/vpa_ppr.sv
module vpa_ppr
   import vpa_pkg::*;
(
   input  prio_t tpr,
   input  logic  isr_found,
   input  prio_t isr_top,
   output prio_t ppr
);
   always_comb begin
      if (isr_found && (prio_class(tpr) < prio_class(isr_top)))
         ppr = {prio_class(isr_top), 4'h0};
      else
         ppr = tpr;
   end

   // R5
   always_comb begin
      ppr_floor_chk: assert (prio_class(ppr) >= prio_class(tpr));
   end
endmodule

// File: rtl/vpa_arbiter.sv
module vpa_arbiter
   import vpa_pkg::*;
#(
   parameter int NUM_VEC         = 256,
   parameter int WORD_W          = 32,
   parameter int SVR_W           = 16,
   parameter bit DIRECTED_EOI_EN = 1'b1,
   localparam int VEC_W          = $clog2(NUM_VEC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_valid,
   input  logic [VEC_W-1:0] set_vector,
   input  logic             set_level,
   input  logic             ack,
   input  logic             eoi,
   input  logic [7:0]       tpr,
   input  logic             svr_wr,
   input  logic [SVR_W-1:0] svr_wdata,
   output logic             irq,
   output logic             ack_valid,
   output logic [7:0]       ack_vector,
   output logic             ack_spurious,
   output logic             eoi_bcast,
   output logic [VEC_W-1:0] eoi_vector
);
   localparam logic [SVR_W-1:0] SVR_RST = SVR_W'(16'h00FF);

   if ((1 << VEC_W) != NUM_VEC || NUM_VEC < 16 || NUM_VEC > 256) begin : g_bad_nvec
      $error("NUM_VEC must be a power of two between 16 and 256");
   end
   if (SVR_W < 13) begin : g_bad_svr
      $error("SVR_W must hold bit 12");
   end

   logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
   logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
   logic [NUM_VEC-1:0] set_bit, grant_bit, retire_bit;
   logic [SVR_W-1:0]   svr_q, svr_keep;
   logic               dir_eoi;

   // Variant: keep or drop the directed bit of the spurious-vector value
   if (DIRECTED_EOI_EN) begin : g_dir
      assign svr_keep = SVR_W'(16'h11FF);
      assign dir_eoi  = svr_q[12];
   end else begin : g_nodir
      assign svr_keep = SVR_W'(16'h01FF);
      assign dir_eoi  = 1'b0;
   end

   logic             irr_found, isr_found;
   logic [VEC_W-1:0] irr_idx, isr_idx;
   prio_t            irr_top, isr_top, ppr;

   vpa_hi_find #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) u_irr_find (
      .bits(irr_q), .found(irr_found), .idx(irr_idx));
   vpa_hi_find #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) u_isr_find (
      .bits(isr_q), .found(isr_found), .idx(isr_idx));

   assign irr_top = prio_t'(irr_idx);
   assign isr_top = prio_t'(isr_idx);

   vpa_ppr u_ppr (
      .tpr(tpr), .isr_found(isr_found), .isr_top(isr_top), .ppr(ppr));

   always_comb begin
      irq = svr_q[8] && irr_found &&
            ((ppr == '0) || (prio_class(irr_top) > prio_class(ppr)));
   end

   always_comb begin
      set_bit    = '0;
      grant_bit  = '0;
      retire_bit = '0;
      if (set_valid)       set_bit[set_vector] = 1'b1;
      if (ack && irq)      grant_bit[irr_idx]  = 1'b1;
      if (eoi && isr_found) retire_bit[isr_idx] = 1'b1;
   end

   always_comb begin
      irr_d = (irr_q & ~grant_bit) | set_bit;
      isr_d = (isr_q & ~retire_bit) | grant_bit;
      if (!set_valid)     tmr_d = tmr_q;
      else if (set_level) tmr_d = tmr_q | set_bit;
      else                tmr_d = tmr_q & ~set_bit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q        <= '0;
         isr_q        <= '0;
         tmr_q        <= '0;
         svr_q        <= SVR_RST;
         ack_valid    <= 1'b0;
         ack_vector   <= '0;
         ack_spurious <= 1'b0;
         eoi_bcast    <= 1'b0;
         eoi_vector   <= '0;
      end else begin
         irr_q     <= irr_d;
         isr_q     <= isr_d;
         tmr_q     <= tmr_d;
         ack_valid <= ack;
         eoi_bcast <= 1'b0;
         if (svr_wr) svr_q <= svr_wdata & svr_keep;
         if (ack) begin
            if (irq) begin
               ack_vector   <= irr_top;
               ack_spurious <= 1'b0;
            end else begin
               ack_vector   <= svr_q[7:0];
               ack_spurious <= 1'b1;
            end
         end
         if (eoi && isr_found && tmr_q[isr_idx] && !dir_eoi) begin
            eoi_bcast  <= 1'b1;
            eoi_vector <= isr_idx;
         end
      end
   end

   // R6
   ack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq) |=> (ack_valid && !ack_spurious));
   // R7
   ack_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !irq) |=> (ack_valid && ack_spurious));
   // R8
   bcast_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bcast |-> $past(eoi));
   // R9
   eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !isr_found) |=> !eoi_bcast);
   // R3
   irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (svr_q[8] && irr_q != '0));
endmodule

// File: tb/tb_vpa_arbiter.sv
`timescale 1ns/1ps
module tb_vpa_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       set_valid = 0, set_level = 0, ack = 0, eoi = 0, svr_wr = 0;
   logic [7:0] set_vector = 0, tpr = 0;
   logic [15:0] svr_wdata = 0;
   logic       irq, ack_valid, ack_spurious, eoi_bcast;
   logic [7:0] ack_vector, eoi_vector;

   always #2.5 clk = ~clk;

   vpa_arbiter dut (
      .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
      .set_level(set_level), .ack(ack), .eoi(eoi), .tpr(tpr), .svr_wr(svr_wr),
      .svr_wdata(svr_wdata), .irq(irq), .ack_valid(ack_valid),
      .ack_vector(ack_vector), .ack_spurious(ack_spurious),
      .eoi_bcast(eoi_bcast), .eoi_vector(eoi_vector));

   int checks = 0, failures = 0;
   bit done = 0;
   bit [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
   bit [15:0]  m_svr = 16'h00FF;
   bit e_av = 0, e_sp = 0, e_bc = 0;
   int e_vec = 0, e_bcv = 0;
   string e_atag = "R11", e_btag = "R11";

   function automatic int hi(bit [255:0] v);
      for (int w = 7; w >= 0; w--)
         for (int b = 31; b >= 0; b--)
            if (v[w*32+b]) return w*32+b;
      return -1;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic step(bit sv, int vec, bit lvl, bit a, bit e, int t,
                       bit sw, int sd, string tag);
      int hi_i, hi_s, ppr;
      bit en, q;
      string itag;
      @(negedge clk);
      set_valid = sv; set_vector = 8'(vec); set_level = lvl;
      ack = a; eoi = e; tpr = 8'(t); svr_wr = sw; svr_wdata = 16'(sd);
      #1;
      en   = m_svr[8];
      hi_i = hi(m_irr);
      hi_s = hi(m_isr);
      ppr  = (hi_s >= 0 && (t >> 4) < (hi_s >> 4)) ? (hi_s & 8'hF0) : t;
      q    = en && hi_i >= 0 && (ppr == 0 || (hi_i >> 4) > (ppr >> 4));
      if (tag != "") itag = tag;
      else if (!en || hi_i < 0) itag = "R3";
      else if (ppr != t) itag = "R5";
      else itag = "R4";
      chk(irq == q, itag, irq, q);
      chk(ack_valid == e_av, e_atag, ack_valid, e_av);
      if (e_av) begin
         chk(ack_spurious == e_sp, e_atag, ack_spurious, e_sp);
         chk(ack_vector == 8'(e_vec), e_atag, ack_vector, e_vec);
      end
      chk(eoi_bcast == e_bc, e_btag, eoi_bcast, e_bc);
      if (e_bc) chk(eoi_vector == 8'(e_bcv), e_btag, eoi_vector, e_bcv);
      e_av = a;
      e_atag = (tag != "") ? tag : (q ? "R6" : "R7");
      if (a) begin
         e_sp  = !q;
         e_vec = q ? hi_i : int'(m_svr[7:0]);
      end
      e_bc   = e && hi_s >= 0 && m_tmr[hi_s] && !m_svr[12];
      e_bcv  = hi_s;
      e_btag = (tag != "") ? tag : (hi_s < 0 ? "R9" : "R8");
      if (a && q) m_irr[hi_i] = 0;
      if (e && hi_s >= 0) m_isr[hi_s] = 0;
      if (a && q) m_isr[hi_i] = 1;
      if (sv) begin
         m_irr[vec] = 1;
         m_tmr[vec] = lvl;
      end
      if (sw) m_svr = 16'(sd) & 16'h11FF;
   endtask

   task automatic idle(int t, string tag);
      step(0, 0, 0, 0, 0, t, 0, 0, tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      idle(0, "R11");
      step(1, 8'h30, 0, 0, 0, 0, 0, 0, "R3");
      idle(0, "R3");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R11");      // spurious 0xFF while disabled
      step(0, 0, 0, 0, 0, 0, 1, 16'hEFFF, "R10"); // keeps 0x01FF
      idle(0, "R10");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R6");        // grants 0x30
      step(0, 0, 0, 0, 1, 0, 0, 0, "R2");        // edge vector: no broadcast
      idle(0, "R9");
      step(0, 0, 0, 0, 1, 0, 0, 0, "R9");        // empty ISR
      idle(0, "R9");
      // R1: ordering across words
      step(1, 8'h21, 0, 0, 0, 0, 0, 0, "R1");
      step(1, 8'hE0, 0, 0, 0, 0, 0, 0, "R1");
      step(1, 8'h9F, 0, 0, 0, 0, 0, 0, "R1");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R1");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R1");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R1");
      repeat (3) step(0, 0, 0, 0, 1, 0, 0, 0, "R8");
      idle(0, "R8");
      // R4: class comparison against task priority
      step(1, 8'h45, 0, 0, 0, 0, 0, 0, "R4");
      idle(8'h50, "R4");
      idle(8'h40, "R4");
      idle(8'h3F, "R4");
      step(0, 0, 0, 1, 0, 8'h50, 0, 0, "R7");     // low priority -> spurious
      idle(0, "R7");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R6");        // 0x45 into service
      // R5: in-service class masks
      step(1, 8'h42, 0, 0, 0, 0, 0, 0, "R5");
      idle(0, "R5");
      step(1, 8'h55, 0, 0, 0, 0, 0, 0, "R5");
      idle(0, "R5");
      // R12: grant and re-set the same vector in one cycle
      step(1, 8'h55, 0, 1, 0, 0, 0, 0, "R12");
      idle(0, "R12");
      step(0, 0, 0, 1, 1, 0, 0, 0, "R12");
      idle(0, "R12");
      repeat (4) step(0, 0, 0, 0, 1, 0, 0, 0, "R8");
      repeat (2) step(0, 0, 0, 1, 0, 0, 0, 0, "R6");
      repeat (3) step(0, 0, 0, 0, 1, 0, 0, 0, "R8");
      // R2 / R8: level vector broadcast, then directed suppression
      step(1, 8'h66, 1, 0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 1, 0, 0, 0, "R2");
      idle(0, "R2");
      step(0, 0, 0, 0, 0, 0, 1, 16'h11FF, "R10");
      step(1, 8'h66, 1, 0, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 1, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 1, 0, 0, 0, "R8");
      idle(0, "R8");
      step(0, 0, 0, 0, 0, 0, 1, 16'h01FF, "R10");
      // random traffic
      for (int i = 0; i < 6000; i++) begin
         int t;
         t = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 255))
                                          : int'(tpr);
         if ($urandom_range(0, 99) < 2)
            step($urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 1),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0, t, 1,
                 ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 65535))
                                             : int'($urandom_range(0, 65535) | 16'h0100),
                 "");
         else
            step($urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 1),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0, t, 0, 0, "");
      end
      idle(0, "");
      idle(0, "");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #900000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog R11 actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule